// File: doc/BRIEF.md
# Serial Scan Memory Test Controller

This block lets a tester drive a set of small on-chip memories through a few pins. A 112-bit command register is filled one bit per clock from a serial input. The register holds a memory selector and two complete port commands, each with an address, a data word, an active-low chip enable, an active-low write enable and a byte-lane mask. When shifting is over, a one-cycle active-low access strobe runs the command against the selected memory. A load pulse then writes the returned read data into the data fields of the register, and the next shift sends the result out on the serial output while a new command goes in.

The selector routes the command to one of three kinds of target. Codes 0 to 4 select independent dual-port 32-bit memories. Codes 8 to 10 select single-port 32-bit memories. Code 11 selects a single-port 64-bit memory. Behavioural register files with synchronous write and combinational read stand in for the real macros. The serial pins are plain level signals with no valid/ready handshake and no back-pressure: each clock with shift enabled moves exactly one bit in and one bit out.

Top module: `scanmem_tester`

## Requirements
- R1: While `scan_en` is high, each clock shifts the register up by one bit and places `scan_in` in bit 0. `scan_out` always shows bit 111, so bits go in and come out most significant first. Field layout from bit 111 down: selector [111:108]; port 0 address [107:92], data [91:60], chip enable [59], write enable [58], mask [57:54]; port 1 address [53:38], data [37:6], chip enable [5], write enable [4], mask [3:0].
- R2: Shifting has priority. A clock with `scan_en` high shifts even if `load_en` is high, and no memory access takes place even if `strobe_n` is low.
- R3: An access takes place on each clock where `strobe_n` is low and `scan_en` is low. A port writes when its chip enable is 0 and its write enable is 0. It reads when its chip enable is 0 and its write enable is 1. It is idle when its chip enable is 1.
- R4: On a write, mask bit k enables byte k (data bits 8k+7 to 8k). A mask of 4'hF writes the whole word, and a byte whose mask bit is 0 keeps its old value.
- R5: A clock with `load_en` high and `scan_en` low copies the data each port read in the most recent access into that port's data field. Every other field keeps its shifted value, and the mask has no effect on a read.
- R6: Each of selectors 0 to 4 reaches its own dual-port memory, and both ports work in the same access. If both ports write the same address, port 1 wins in every byte lane that both masks enable.
- R7: If one port of a dual-port memory reads the address the other port writes in the same access, the read returns the contents from before the write.
- R8: Selectors 8 to 10 use only the port 0 fields. The port 1 fields cause no write, and a load leaves the port 1 data field unchanged.
- R9: Selector 11 takes its address, chip enable and write enable from port 0. The port 0 data and mask form the low 32 bits and the port 1 data and mask form the high 32 bits. A read loads the low word into the port 0 data field and the high word into the port 1 data field.
- R10: Selectors 5 to 7 and 12 to 15 access no memory, and a load after such an access leaves both data fields unchanged.
- R11: After reset the register, `scan_out` and all memory words are zero.
- R12: With `scan_en` and `load_en` both low, the register holds its contents. A port that did not read in the most recent access keeps its data field on load.
- R13: A port address at or above the memory depth (16 words by default) makes that port do nothing: no write, no aliasing onto a lower address, and its data field is unchanged on load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and access clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift enable for the command register |
| scan_in | input | 1 | Serial data in, most significant bit first |
| load_en | input | 1 | Copies captured read data into the register |
| strobe_n | input | 1 | Active-low access strobe |
| scan_out | output | 1 | Serial data out, the register's top bit |

## Verification
Two pairs of functions can fall in the same cycle. The first is shifting and loading. The second is shifting and the access strobe. The bench shifts a complete word with `load_en` high and `strobe_n` low for the whole shift. It then checks that the word shifted out is exactly the previous contents with no data replaced and no bit slip. It also checks that the write command that passed through the register during that shift never reached the memory. A second same-cycle case is two ports working on one address in one access. It is judged by write collisions, where port 1's bytes must survive, and by a read of an address being written, which must return the old value.

// File: rtl/scanmem_pkg.sv
package scanmem_pkg;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int MASK_W = DATA_W / 8;
  localparam int PORT_W = ADDR_W + DATA_W + 2 + MASK_W;
  localparam int SCAN_W = SEL_W + 2 * PORT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              cs_n;
    logic              we_n;
    logic [MASK_W-1:0] mask;
  } port_cmd_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    port_cmd_t        p0;
    port_cmd_t        p1;
  } scan_word_t;
endpackage

// File: rtl/mem_sp.sv
module mem_sp #(
  parameter int DEPTH = 16,
  parameter int LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] addr,
  input  logic [8*LANES-1:0]             wdata,
  input  logic [LANES-1:0]               mask,
  output logic [8*LANES-1:0]             rdata
);
  localparam int W = 8 * LANES;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
    end else if (we) begin
      for (int k = 0; k < LANES; k++)
        if (mask[k]) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/mem_dp.sv
module mem_dp #(
  parameter int DEPTH = 16,
  parameter int LANES = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we_a,
  input  logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] addr_a,
  input  logic [8*LANES-1:0]                   wdata_a,
  input  logic [LANES-1:0]                     mask_a,
  output logic [8*LANES-1:0]                   rdata_a,
  input  logic                                 we_b,
  input  logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] addr_b,
  input  logic [8*LANES-1:0]                   wdata_b,
  input  logic [LANES-1:0]                     mask_b,
  output logic [8*LANES-1:0]                   rdata_b
);
  localparam int W = 8 * LANES;

  logic [W-1:0] mem [DEPTH];

  // Port b is applied after port a, so on a shared address its lanes win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (we_a && mask_a[k]) mem[addr_a][8*k +: 8] <= wdata_a[8*k +: 8];
        if (we_b && mask_b[k]) mem[addr_b][8*k +: 8] <= wdata_b[8*k +: 8];
      end
    end
  end

  assign rdata_a = mem[addr_a];
  assign rdata_b = mem[addr_b];
endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import scanmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  input  logic              load_en,
  input  logic              cap0_v,
  input  logic [DATA_W-1:0] cap0_d,
  input  logic              cap1_v,
  input  logic [DATA_W-1:0] cap1_d,
  output scan_word_t        word,
  output logic              scan_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (scan_en) begin
      word <= {word[SCAN_W-2:0], scan_in};
    end else if (load_en) begin
      if (cap0_v) word.p0.data <= cap0_d;
      if (cap1_v) word.p1.data <= cap1_d;
    end
  end

  assign scan_out = word[SCAN_W-1];

  // Everything except the two data fields, for the load check.
  logic [SCAN_W-2*DATA_W-1:0] ctrl_view;
  assign ctrl_view = {word.sel,
                      word.p0.addr, word.p0.cs_n, word.p0.we_n, word.p0.mask,
                      word.p1.addr, word.p1.cs_n, word.p1.we_n, word.p1.mask};

  AST_SHIFT_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && load_en) |=> (word[0] == $past(scan_in)) &&
                             (word[SCAN_W-1:1] == $past(word[SCAN_W-2:0]))); // R2

  AST_LOAD_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && load_en) |=> $stable(ctrl_view)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !load_en) |=> $stable(word)); // R12
endmodule

// File: rtl/access_router.sv
module access_router
  import scanmem_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int N_DP     = 5,
  parameter int SP_BASE  = 8,
  parameter int N_SP     = 3,
  parameter int WIDE_SEL = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  scan_word_t        cmd,
  output logic              cap0_v,
  output logic [DATA_W-1:0] cap0_d,
  output logic              cap1_v,
  output logic [DATA_W-1:0] cap1_d
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

  // Per-port command decode
  logic in0, in1, wr0, wr1, rd0, rd1;
  logic [AW-1:0] a0, a1;

  assign in0 = (cmd.p0.addr <= TOP_ADDR);
  assign in1 = (cmd.p1.addr <= TOP_ADDR);
  assign a0  = cmd.p0.addr[AW-1:0];
  assign a1  = cmd.p1.addr[AW-1:0];
  assign wr0 = go && in0 && !cmd.p0.cs_n && !cmd.p0.we_n;
  assign rd0 = go && in0 && !cmd.p0.cs_n &&  cmd.p0.we_n;
  assign wr1 = go && in1 && !cmd.p1.cs_n && !cmd.p1.we_n;
  assign rd1 = go && in1 && !cmd.p1.cs_n &&  cmd.p1.we_n;

  // Target decode
  logic [N_DP-1:0] hit_dp, dp_we0, dp_we1;
  logic [N_SP-1:0] hit_sp, sp_we;
  logic            hit_wide, wide_we, any_hit;

  logic [DATA_W-1:0]   dp_rd0 [N_DP];
  logic [DATA_W-1:0]   dp_rd1 [N_DP];
  logic [DATA_W-1:0]   sp_rd  [N_SP];
  logic [2*DATA_W-1:0] wide_rd;

  genvar gi;
  generate
    for (gi = 0; gi < N_DP; gi++) begin : g_dp
      assign hit_dp[gi] = (cmd.sel == SEL_W'(gi));
      assign dp_we0[gi] = hit_dp[gi] && wr0;
      assign dp_we1[gi] = hit_dp[gi] && wr1;
      mem_dp #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (dp_we0[gi]),
        .addr_a  (a0),
        .wdata_a (cmd.p0.data),
        .mask_a  (cmd.p0.mask),
        .rdata_a (dp_rd0[gi]),
        .we_b    (dp_we1[gi]),
        .addr_b  (a1),
        .wdata_b (cmd.p1.data),
        .mask_b  (cmd.p1.mask),
        .rdata_b (dp_rd1[gi])
      );
    end
    for (gi = 0; gi < N_SP; gi++) begin : g_sp
      assign hit_sp[gi] = (cmd.sel == SEL_W'(SP_BASE + gi));
      assign sp_we[gi]  = hit_sp[gi] && wr0;
      mem_sp #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sp_we[gi]),
        .addr  (a0),
        .wdata (cmd.p0.data),
        .mask  (cmd.p0.mask),
        .rdata (sp_rd[gi])
      );
    end
  endgenerate

  // Wide memory: port 0 fields form the low half, port 1 data/mask the high half.
  assign hit_wide = (cmd.sel == SEL_W'(WIDE_SEL));
  assign wide_we  = hit_wide && wr0;

  mem_sp #(.DEPTH(DEPTH), .LANES(2 * LANES)) u_wide (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wide_we),
    .addr  (a0),
    .wdata ({cmd.p1.data, cmd.p0.data}),
    .mask  ({cmd.p1.mask, cmd.p0.mask}),
    .rdata (wide_rd)
  );

  assign any_hit = (|hit_dp) || (|hit_sp) || hit_wide;

  // Read return mux
  logic              ok0, ok1;
  logic [DATA_W-1:0] mux0, mux1;

  always_comb begin
    ok0  = 1'b0;
    ok1  = 1'b0;
    mux0 = '0;
    mux1 = '0;
    for (int i = 0; i < N_DP; i++) begin
      if (hit_dp[i]) begin
        ok0  = rd0;
        ok1  = rd1;
        mux0 = dp_rd0[i];
        mux1 = dp_rd1[i];
      end
    end
    for (int i = 0; i < N_SP; i++) begin
      if (hit_sp[i]) begin
        ok0  = rd0;
        mux0 = sp_rd[i];
      end
    end
    if (hit_wide) begin
      ok0  = rd0;
      ok1  = rd0;
      mux0 = wide_rd[DATA_W-1:0];
      mux1 = wide_rd[2*DATA_W-1:DATA_W];
    end
  end

  // Capture at the access edge (old contents: read before write)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap0_v <= 1'b0;
      cap1_v <= 1'b0;
      cap0_d <= '0;
      cap1_d <= '0;
    end else if (go) begin
      cap0_v <= ok0;
      cap1_v <= ok1;
      if (ok0) cap0_d <= mux0;
      if (ok1) cap1_d <= mux1;
    end
  end

  AST_NO_WRITE_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !((|dp_we0) || (|dp_we1) || (|sp_we) || wide_we)); // R3

  AST_UNUSED_SEL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !any_hit) |=> (!cap0_v && !cap1_v)); // R10

  AST_SINGLE_PORT1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (|hit_sp)) |=> !cap1_v); // R8

  AST_WIDE_BOTH_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hit_wide && rd0) |=> (cap0_v && cap1_v)); // R9

  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !in0 && !in1) |=> (!cap0_v && !cap1_v)); // R13
endmodule

// File: rtl/scanmem_tester.sv
module scanmem_tester
  import scanmem_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int N_DP     = 5,
  parameter int SP_BASE  = 8,
  parameter int N_SP     = 3,
  parameter int WIDE_SEL = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_in,
  input  logic load_en,
  input  logic strobe_n,
  output logic scan_out
);
  scan_word_t        word;
  logic              go;
  logic              cap0_v, cap1_v;
  logic [DATA_W-1:0] cap0_d, cap1_d;

  // Access only when the strobe is low and the register is not shifting.
  assign go = !strobe_n && !scan_en;

  scan_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .load_en  (load_en),
    .cap0_v   (cap0_v),
    .cap0_d   (cap0_d),
    .cap1_v   (cap1_v),
    .cap1_d   (cap1_d),
    .word     (word),
    .scan_out (scan_out)
  );

  access_router #(
    .DEPTH    (DEPTH),
    .N_DP     (N_DP),
    .SP_BASE  (SP_BASE),
    .N_SP     (N_SP),
    .WIDE_SEL (WIDE_SEL)
  ) u_router (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .cmd    (word),
    .cap0_v (cap0_v),
    .cap0_d (cap0_d),
    .cap1_v (cap1_v),
    .cap1_d (cap1_d)
  );

  AST_SCAN_FREEZES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> $stable({cap0_v, cap1_v, cap0_d, cap1_d})); // R2

  AST_RESET_OUT_LOW: assert property (@(posedge clk)
    !rst_n |-> !scan_out); // R11
endmodule

// File: tb/tb_scanmem_tester.sv
module tb_scanmem_tester;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic load_en = 1'b0;
  logic strobe_n = 1'b1;
  logic scan_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scanmem_tester dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .load_en(load_en), .strobe_n(strobe_n), .scan_out(scan_out)
  );

  // Field layout from R1
  function automatic logic [111:0] mk(
    input logic [3:0] s,
    input logic [15:0] a0, input logic [31:0] d0, input logic c0, input logic w0, input logic [3:0] m0,
    input logic [15:0] a1, input logic [31:0] d1, input logic c1, input logic w1, input logic [3:0] m1);
    return {s, a0, d0, c0, w0, m0, a1, d1, c1, w1, m1};
  endfunction

  function automatic logic [31:0] xv(input int i); return 32'hA000_0000 | i; endfunction
  function automatic logic [31:0] yv(input int i); return 32'hB000_0000 | (i << 4); endfunction

  task automatic check(input string req, input logic [111:0] act, input logic [111:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [111:0] w, input bit ld, input bit stb,
                            output logic [111:0] got);
    for (int j = 0; j < 112; j++) begin
      @(negedge clk);
      got[111-j] = scan_out;
      scan_in  = w[111-j];
      scan_en  = 1'b1;
      load_en  = ld;
      strobe_n = !stb;
    end
    @(negedge clk);
    scan_en  = 1'b0;
    load_en  = 1'b0;
    strobe_n = 1'b1;
    scan_in  = 1'b0;
  endtask

  task automatic access(input logic [111:0] cmd);
    logic [111:0] junk;
    shift_word(cmd, 1'b0, 1'b0, junk);
    strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
    load_en  = 1'b1;
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  task automatic readback(output logic [111:0] got);
    shift_word('0, 1'b0, 1'b0, got);
  endtask

  task automatic t_reset;
    logic [111:0] got;
    check("R11 scan_out", {111'd0, scan_out}, '0);
    readback(got);
    check("R11 register", got, '0);
    access(mk(4'd3, 16'd9, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R11 memory", got, mk(4'd3, 16'd9, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_shift;
    logic [111:0] pat, got;
    pat = {32'hC3A5_0F96, 32'h1234_5678, 32'h8765_4321, 16'hE01B};
    shift_word(pat, 1'b0, 1'b0, got);
    check("R1 msb on scan_out", {111'd0, scan_out}, {111'd0, pat[111]});
    readback(got);
    check("R1 round trip", got, pat);
  endtask

  task automatic t_dual;
    logic [111:0] got;
    for (int i = 0; i < 5; i++)
      access(mk(4'(i), 16'd1, xv(i), 1'b0, 1'b0, 4'hF, 16'd2, yv(i), 1'b0, 1'b0, 4'hF));
    for (int i = 0; i < 5; i++) begin
      access(mk(4'(i), 16'd1, 32'hDEAD_0000, 1'b0, 1'b1, 4'h0, 16'd2, 32'hBEEF_0000, 1'b0, 1'b1, 4'h0));
      readback(got);
      check("R3 R5 R6 dual read", got,
            mk(4'(i), 16'd1, xv(i), 1'b0, 1'b1, 4'h0, 16'd2, yv(i), 1'b0, 1'b1, 4'h0));
    end
  endtask

  task automatic t_mask;
    logic [111:0] got;
    access(mk(4'd0, 16'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    access(mk(4'd0, 16'd3, 32'h0, 1'b0, 1'b0, 4'b0101, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    access(mk(4'd0, 16'd3, 32'h0, 1'b0, 1'b1, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R4 byte mask", got, mk(4'd0, 16'd3, 32'hFF00_FF00, 1'b0, 1'b1, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_collide;
    logic [111:0] got;
    access(mk(4'd1, 16'd5, 32'h1111_1111, 1'b0, 1'b0, 4'hF, 16'd5, 32'h2222_2222, 1'b0, 1'b0, 4'b0011));
    access(mk(4'd1, 16'd5, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R6 port 1 wins", got, mk(4'd1, 16'd5, 32'h1111_2222, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_rbw;
    logic [111:0] got;
    access(mk(4'd2, 16'd6, 32'hAAAA_5555, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    access(mk(4'd2, 16'd6, 32'h1234_5678, 1'b0, 1'b0, 4'hF, 16'd6, 32'h0, 1'b0, 1'b1, 4'h0));
    readback(got);
    check("R7 old data", got, mk(4'd2, 16'd6, 32'h1234_5678, 1'b0, 1'b0, 4'hF, 16'd6, 32'hAAAA_5555, 1'b0, 1'b1, 4'h0));
    access(mk(4'd2, 16'd6, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R7 new data", got, mk(4'd2, 16'd6, 32'h1234_5678, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_single;
    logic [111:0] got;
    for (int s = 8; s < 11; s++) begin
      access(mk(4'(s), 16'd1, 32'hC000_0000 | s, 1'b0, 1'b0, 4'hF, 16'd1, 32'h7777_7777, 1'b0, 1'b0, 4'hF));
      access(mk(4'(s), 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'd1, 32'h55, 1'b0, 1'b1, 4'h0));
      readback(got);
      check("R8 single port", got,
            mk(4'(s), 16'd1, 32'hC000_0000 | s, 1'b0, 1'b1, 4'h0, 16'd1, 32'h55, 1'b0, 1'b1, 4'h0));
    end
  endtask

  task automatic t_wide;
    logic [111:0] got;
    access(mk(4'd11, 16'd3, 32'h0BAD_F00D, 1'b0, 1'b0, 4'hF, 16'd9, 32'hCAFE_BABE, 1'b1, 1'b1, 4'b1100));
    access(mk(4'd11, 16'd3, 32'h0, 1'b0, 1'b1, 4'h0, 16'd9, 32'h1357_9BDF, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R9 wide halves", got,
          mk(4'd11, 16'd3, 32'h0BAD_F00D, 1'b0, 1'b1, 4'h0, 16'd9, 32'hCAFE_0000, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_unused;
    logic [111:0] got, cmd;
    for (int k = 0; k < 2; k++) begin
      logic [3:0] s;
      s = (k == 0) ? 4'd5 : 4'd12;
      access(mk(s, 16'd1, 32'hBAD0_0001, 1'b0, 1'b0, 4'hF, 16'd2, 32'hBAD0_0002, 1'b0, 1'b0, 4'hF));
      cmd = mk(s, 16'd1, 32'h11, 1'b0, 1'b1, 4'h0, 16'd2, 32'h22, 1'b0, 1'b1, 4'h0);
      access(cmd);
      readback(got);
      check("R10 unused select", got, cmd);
    end
    access(mk(4'd0, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'd2, 32'h0, 1'b0, 1'b1, 4'h0));
    readback(got);
    check("R10 no stray write", got, mk(4'd0, 16'd1, xv(0), 1'b0, 1'b1, 4'h0, 16'd2, yv(0), 1'b0, 1'b1, 4'h0));
  endtask

  task automatic t_range;
    logic [111:0] got, cmd;
    access(mk(4'd4, 16'd17, 32'hEEEE_EEEE, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    access(mk(4'd4, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    readback(got);
    check("R13 no alias", got, mk(4'd4, 16'd1, xv(4), 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    cmd = mk(4'd4, 16'd17, 32'h33, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    access(cmd);
    readback(got);
    check("R13 no read", got, cmd);
  endtask

  task automatic t_priority;
    logic [111:0] got, cmd, w2;
    cmd = mk(4'd0, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    w2  = mk(4'd0, 16'd1, 32'hDEAD_DEAD, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_word(cmd, 1'b0, 1'b0, got);
    strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
    shift_word(w2, 1'b1, 1'b1, got);
    check("R2 shift over load", got, cmd);
    readback(got);
    check("R2 shifted word intact", got, w2);
    access(cmd);
    readback(got);
    check("R2 no access while shifting", got,
          mk(4'd0, 16'd1, xv(0), 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
  endtask

  task automatic t_hold;
    logic [111:0] got, cmd, pat;
    cmd = mk(4'd0, 16'd4, 32'h4444_4444, 1'b0, 1'b0, 4'hF, 16'd5, 32'h5555_5555, 1'b1, 1'b1, 4'hF);
    access(cmd);
    readback(got);
    check("R12 write leaves data", got, cmd);
    pat = {56'hF0E1_D2C3_B4A5_96, 56'h8778_6959_4A3B_2C};
    shift_word(pat, 1'b0, 1'b0, got);
    repeat (10) @(negedge clk);
    readback(got);
    check("R12 idle hold", got, pat);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shift();
    t_dual();
    t_mask();
    t_collide();
    t_rbw();
    t_single();
    t_wide();
    t_unused();
    t_range();
    t_priority();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule